// File: doc/BRIEF.md
# No-Wait Pipelined Synchronous SRAM

This block is a single-port, word-wide synchronous memory. Reads and writes may follow each other in any order on every clock, with no idle cycle when the bus turns around. Every control input, the address and the lane write enables are registered on the rising clock edge. Read data appears two enabled edges after its command. Write data is taken from the data input at the edge two enabled edges after its command, which is the slot where read data would otherwise sit. Because both directions use the same slot, a read can follow a write directly, and a write can follow a read directly.

A command starts when the three select inputs are in their active combination and the advance/load input is low. With advance/load high, a two-bit beat counter steps through the four words of an aligned group. The direction of that burst was fixed at its first beat. A hold input freezes the whole pipeline, including the memory write, for as long as it is high. The shared data bus is modelled as separate input, output and drive-enable ports.

Top module: `nowait_sram`

## Requirements
- R1: A read command that is sampled at an enabled edge drives its word on `dq_out` after the following enabled edge, with `dq_oe` high while `oe_n` is low. The value read is the memory content after every earlier write has completed.
- R2: The write data for a write command is taken from `dq_in` at the second enabled edge after the command. `dq_oe` stays low during that slot. Reads and writes can be issued back to back in any mix, with no idle cycles between them.
- R3: `ben_n` is active low. Bit 0 gates data bits 7:0, bit 1 gates 15:8, bit 2 gates 23:16 and bit 3 gates 31:24. With all bits low the whole word is written. Lanes whose bit is high keep their old content.
- R4: An edge at which `clk_hold` is high has no effect. `dq_out`, the pipeline, the burst state and the memory all keep their values. A pending write takes its data at the next edge where `clk_hold` is low.
- R5: The block is selected when `sel1_n` is low, `sel2` is high and `sel3_n` is low. A command starts when the block is selected and `adv_ld` is low. `rd_wrn` high means read and `rd_wrn` low means write.
- R6: When `adv_ld` is low and the block is not selected, the block is deselected. `dq_oe` is low after the second enabled edge counted from the deselect edge. A write issued with a bad select does not change the memory.
- R7: When `adv_ld` is high and a burst is open, the beat counter advances. `rd_wrn` is ignored, and the beat keeps the direction of the burst's first command. Each beat samples its own `ben_n`. When `adv_ld` is high and no burst is open, nothing is issued.
- R8: Beat k (k = 1, 2, 3, then wrapping) uses the start address with its two low bits replaced by (start[1:0] XOR k) in the default interleaved order. With `BURST_LINEAR` set, those bits are (start[1:0] + k) mod 4. The upper bits never change.
- R9: While `oe_n` is high, `dq_oe` is low.
- R10: A read issued on the edge right after a write to the same address returns the word with that write's enabled lanes merged in.
- R11: Reset clears the pipeline and the burst state. `dq_oe` is low during and after reset. The memory contents are not initialised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_hold | input | 1 | High: the edge is ignored entirely |
| addr | input | ADDR_W | Word address, used on load cycles |
| rd_wrn | input | 1 | High read, low write, used on load cycles |
| sel1_n | input | 1 | Select, active low |
| sel2 | input | 1 | Select, active high |
| sel3_n | input | 1 | Select, active low |
| adv_ld | input | 1 | Low: load or deselect; high: advance the burst |
| ben_n | input | DATA_W/8 | Active-low lane write enables |
| oe_n | input | 1 | Active-low output enable |
| dq_in | input | DATA_W | Write data from the bus |
| dq_out | output | DATA_W | Read data to the bus |
| dq_oe | output | 1 | Bus drive enable |

## Verification
The checker watches the bus timing on every cycle. A loaded read must drive in its slot, a loaded write's slot must stay undriven, and a deselect must release the bus. It also checks that held edges leave the read data unchanged and that `oe_n` gates the drivers. The bench's reference model is the only place that checks data values: lane merging, forwarding from a write to the read right behind it, burst address order, direction kept through a burst, and writes that complete late after hold cycles.

// File: rtl/nwsram_pkg.sv
package nwsram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  localparam int unsigned LANE_W = 8;
  localparam int unsigned BEAT_W = 2;
endpackage

// File: rtl/sram_burst_seq.sv
module sram_burst_seq
  import nwsram_pkg::*;
#(
  parameter int unsigned ADDR_W       = 10,
  parameter int unsigned NB           = 4,
  parameter bit          BURST_LINEAR = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              sel_ok,
  input  logic              adv,
  input  logic              rd_wrn,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [NB-1:0]     ben_in,
  output op_e               op_out,
  output logic [ADDR_W-1:0] addr_out,
  output logic [NB-1:0]     ben_out
);
  logic              act_q, act_d;
  logic              wr_q, wr_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic [BEAT_W-1:0] beat_inc;
  logic [BEAT_W-1:0] low_nxt;

  assign beat_inc = beat_q + BEAT_W'(1);

  // R8: order of the low address bits within a burst
  generate
    if (BURST_LINEAR) begin : g_linear
      assign low_nxt = base_q[BEAT_W-1:0] + beat_inc;
    end else begin : g_interleave
      assign low_nxt = base_q[BEAT_W-1:0] ^ beat_inc;
    end
  endgenerate

  always_comb begin
    act_d    = act_q;
    wr_d     = wr_q;
    base_d   = base_q;
    beat_d   = beat_q;
    op_out   = OP_IDLE;
    addr_out = addr_in;
    ben_out  = ben_in;
    if (!adv) begin
      if (sel_ok) begin
        act_d  = 1'b1;
        wr_d   = ~rd_wrn;
        base_d = addr_in;
        beat_d = '0;
        op_out = rd_wrn ? OP_READ : OP_WRITE;
      end else begin
        act_d = 1'b0;
      end
    end else if (act_q) begin
      beat_d   = beat_inc;
      op_out   = wr_q ? OP_WRITE : OP_READ;
      addr_out = {base_q[ADDR_W-1:BEAT_W], low_nxt};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
    end else if (!hold) begin
      act_q <= act_d;
    end
  end

  always_ff @(posedge clk) begin
    if (!hold) begin
      wr_q   <= wr_d;
      base_q <= base_d;
      beat_q <= beat_d;
    end
  end
endmodule

// File: rtl/sram_pipe.sv
module sram_pipe
  import nwsram_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned NB     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  op_e               in_op,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [NB-1:0]     in_ben,
  output op_e               s1_op,
  output logic [ADDR_W-1:0] s1_addr,
  output op_e               s2_op,
  output logic [ADDR_W-1:0] s2_addr,
  output logic [NB-1:0]     s2_ben
);
  logic [NB-1:0] s1_ben;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_op <= OP_IDLE;
      s2_op <= OP_IDLE;
    end else if (!hold) begin
      s1_op <= in_op;
      s2_op <= s1_op;
    end
  end

  always_ff @(posedge clk) begin
    if (!hold) begin
      s1_addr <= in_addr;
      s1_ben  <= in_ben;
      s2_addr <= s1_addr;
      s2_ben  <= s1_ben;
    end
  end
endmodule

// File: rtl/sram_core.sv
module sram_core
  import nwsram_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     hold,
  input  logic                     rd_en,
  input  logic [ADDR_W-1:0]        rd_addr,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W/LANE_W-1:0] wr_ben_n,
  input  logic [DATA_W-1:0]        wr_data,
  output logic [DATA_W-1:0]        rd_data
);
  localparam int unsigned NB    = DATA_W / LANE_W;
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] word_now;
  logic [DATA_W-1:0] word_fwd;
  logic              fwd_hit;

  assign word_now = mem[rd_addr];
  assign fwd_hit  = wr_en && (wr_addr == rd_addr);

  // R10: the write that completes at this edge is merged into the read
  always_comb begin
    word_fwd = word_now;
    if (fwd_hit) begin
      for (int b = 0; b < NB; b++) begin
        if (!wr_ben_n[b]) begin
          word_fwd[b*LANE_W +: LANE_W] = wr_data[b*LANE_W +: LANE_W];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!hold) begin
      if (wr_en) begin
        for (int b = 0; b < NB; b++) begin
          if (!wr_ben_n[b]) begin
            mem[wr_addr][b*LANE_W +: LANE_W] <= wr_data[b*LANE_W +: LANE_W];
          end
        end
      end
      if (rd_en) begin
        rd_data <= word_fwd;
      end
    end
  end
endmodule

// File: rtl/nowait_sram.sv
module nowait_sram #(
  parameter int unsigned ADDR_W       = 10,
  parameter int unsigned DATA_W       = 32,
  parameter bit          BURST_LINEAR = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clk_hold,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                rd_wrn,
  input  logic                sel1_n,
  input  logic                sel2,
  input  logic                sel3_n,
  input  logic                adv_ld,
  input  logic [DATA_W/8-1:0] ben_n,
  input  logic                oe_n,
  input  logic [DATA_W-1:0]   dq_in,
  output logic [DATA_W-1:0]   dq_out,
  output logic                dq_oe
);
  import nwsram_pkg::*;

  localparam int unsigned NB = DATA_W / LANE_W;

  logic              sel_ok;
  op_e               iss_op;
  logic [ADDR_W-1:0] iss_addr;
  logic [NB-1:0]     iss_ben;
  op_e               s1_op;
  logic [ADDR_W-1:0] s1_addr;
  op_e               s2_op;
  logic [ADDR_W-1:0] s2_addr;
  logic [NB-1:0]     s2_ben;

  assign sel_ok = ~sel1_n & sel2 & ~sel3_n;

  sram_burst_seq #(
    .ADDR_W      (ADDR_W),
    .NB          (NB),
    .BURST_LINEAR(BURST_LINEAR)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold    (clk_hold),
    .sel_ok  (sel_ok),
    .adv     (adv_ld),
    .rd_wrn  (rd_wrn),
    .addr_in (addr),
    .ben_in  (ben_n),
    .op_out  (iss_op),
    .addr_out(iss_addr),
    .ben_out (iss_ben)
  );

  sram_pipe #(
    .ADDR_W(ADDR_W),
    .NB    (NB)
  ) u_pipe (
    .clk    (clk),
    .rst_n  (rst_n),
    .hold   (clk_hold),
    .in_op  (iss_op),
    .in_addr(iss_addr),
    .in_ben (iss_ben),
    .s1_op  (s1_op),
    .s1_addr(s1_addr),
    .s2_op  (s2_op),
    .s2_addr(s2_addr),
    .s2_ben (s2_ben)
  );

  sram_core #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_core (
    .clk     (clk),
    .hold    (clk_hold),
    .rd_en   (s1_op == OP_READ),
    .rd_addr (s1_addr),
    .wr_en   (s2_op == OP_WRITE),
    .wr_addr (s2_addr),
    .wr_ben_n(s2_ben),
    .wr_data (dq_in),
    .rd_data (dq_out)
  );

  assign dq_oe = (s2_op == OP_READ) & ~oe_n;
endmodule

// File: rtl/nowait_sram_chk.sv
module nowait_sram_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_hold,
  input logic              rd_wrn,
  input logic              sel1_n,
  input logic              sel2,
  input logic              sel3_n,
  input logic              adv_ld,
  input logic              oe_n,
  input logic [DATA_W-1:0] dq_out,
  input logic              dq_oe
);
  logic picked, load_rd, load_wr, desel;

  assign picked  = !sel1_n && sel2 && !sel3_n;
  assign load_rd = picked && !adv_ld && rd_wrn && !clk_hold;
  assign load_wr = picked && !adv_ld && !rd_wrn && !clk_hold;
  assign desel   = !picked && !adv_ld && !clk_hold;

  AST_READ_SLOT_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    load_rd ##1 !clk_hold |=> (dq_oe == !oe_n)); // R1

  AST_WRITE_SLOT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    load_wr ##1 !clk_hold |=> !dq_oe); // R2

  AST_DESELECT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    desel ##1 !clk_hold |=> !dq_oe); // R6

  AST_HOLD_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    clk_hold |=> $stable(dq_out)); // R4

  AST_OE_GATES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_oe); // R9
endmodule

bind nowait_sram nowait_sram_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .clk_hold(clk_hold),
  .rd_wrn  (rd_wrn),
  .sel1_n  (sel1_n),
  .sel2    (sel2),
  .sel3_n  (sel3_n),
  .adv_ld  (adv_ld),
  .oe_n    (oe_n),
  .dq_out  (dq_out),
  .dq_oe   (dq_oe)
);

// File: tb/nowait_sram_tb_top.sv
module nowait_sram_tb_top;
  localparam int unsigned AW = 10;
  localparam int unsigned DW = 32;

  logic          clk;
  logic          rst_n;
  logic          clk_hold;
  logic [AW-1:0] addr;
  logic          rd_wrn;
  logic          sel1_n, sel2, sel3_n;
  logic          adv_ld;
  logic [3:0]    ben_n;
  logic          oe_n;
  logic [DW-1:0] dq_in;
  logic [DW-1:0] dq_out;
  logic          dq_oe;

  int    checks = 0;
  int    fails  = 0;
  string cur_req = "R11";
  bit    oe_cur = 1'b0;
  logic [31:0] cyc_n = 32'd1;

  nowait_sram #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .clk_hold(clk_hold), .addr(addr), .rd_wrn(rd_wrn),
    .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n), .adv_ld(adv_ld), .ben_n(ben_n),
    .oe_n(oe_n), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  initial clk = 1'b0;
  always #2.5ns clk = ~clk;

  // ---------------- behavioural reference model ----------------
  typedef struct {
    int          kind;   // 0 idle, 1 read, 2 write
    int unsigned adr;
    logic [3:0]  ben;
    logic [31:0] data;
    logic [3:0]  known;
  } mop_t;

  mop_t        hist[$];
  logic [31:0] mmem   [int unsigned];
  logic [3:0]  mknown [int unsigned];
  bit          b_on, b_wr;
  int unsigned b_base;
  int unsigned b_beat;

  function automatic mop_t idle_op();
    mop_t o;
    o.kind = 0; o.adr = 0; o.ben = 4'hF; o.data = '0; o.known = '0;
    return o;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    mop_t w, r, n;
    if (!rst_n) begin
      hist.delete();
      hist.push_back(idle_op());
      hist.push_back(idle_op());
      b_on = 1'b0;
    end else if (!clk_hold) begin
      w = hist[hist.size()-2];
      r = hist[hist.size()-1];
      if (w.kind == 2) begin
        if (!mmem.exists(w.adr)) begin
          mmem[w.adr]   = '0;
          mknown[w.adr] = '0;
        end
        for (int b = 0; b < 4; b++) begin
          if (!w.ben[b]) begin
            mmem[w.adr][b*8 +: 8] = dq_in[b*8 +: 8];
            mknown[w.adr][b]      = 1'b1;
          end
        end
      end
      if (r.kind == 1) begin
        r.data  = mmem.exists(r.adr) ? mmem[r.adr] : '0;
        r.known = mknown.exists(r.adr) ? mknown[r.adr] : '0;
        hist[hist.size()-1] = r;
      end
      n = idle_op();
      n.ben = ben_n;
      if (!adv_ld) begin
        if (!sel1_n && sel2 && !sel3_n) begin
          n.kind = rd_wrn ? 1 : 2;
          n.adr  = addr;
          b_on = 1'b1; b_wr = !rd_wrn; b_base = addr; b_beat = 0;
        end else begin
          b_on = 1'b0;
        end
      end else if (b_on) begin
        b_beat = (b_beat + 1) % 4;
        n.kind = b_wr ? 2 : 1;
        n.adr  = (b_base & ~32'd3) | ((b_base ^ b_beat) & 32'd3);
      end
      hist.push_back(n);
      if (hist.size() > 4) void'(hist.pop_front());
    end
  end

  task automatic compare();
    mop_t d;
    bit   exp_oe;
    if (hist.size() < 2) return;
    d = hist[hist.size()-2];
    exp_oe = (d.kind == 1) && !oe_n;
    checks++;
    if (dq_oe !== exp_oe) begin
      fails++;
      $display("FAIL %s: dq_oe actual=%0b expected=%0b", cur_req, dq_oe, exp_oe);
    end
    if (exp_oe) begin
      checks++;
      for (int b = 0; b < 4; b++) begin
        if (d.known[b] && dq_out[b*8 +: 8] !== d.data[b*8 +: 8]) begin
          fails++;
          $display("FAIL %s: dq_out lane %0d actual=%h expected=%h (addr %0d)",
                   cur_req, b, dq_out[b*8 +: 8], d.data[b*8 +: 8], d.adr);
        end
      end
    end
  endtask

  // ---------------- stimulus ----------------
  task automatic drive(bit hold, bit s1n, bit s2, bit s3n, bit adv, bit rw,
                       logic [3:0] be, int unsigned a);
    clk_hold = hold; sel1_n = s1n; sel2 = s2; sel3_n = s3n;
    adv_ld = adv; rd_wrn = rw; ben_n = be; addr = AW'(a); oe_n = oe_cur;
    dq_in = 32'h9E37_79B9 * cyc_n + 32'h0135_7BDF;
    cyc_n = cyc_n + 1;
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic rd(int unsigned a);
    drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF, a);
  endtask
  task automatic wr(int unsigned a, logic [3:0] be);
    drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, be, a);
  endtask
  task automatic desel();
    drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF, 0);
  endtask
  task automatic beat(bit rw, logic [3:0] be);
    drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, rw, be, 0);
  endtask
  task automatic held();
    drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; clk_hold = 1'b0; sel1_n = 1'b1; sel2 = 1'b0; sel3_n = 1'b1;
    adv_ld = 1'b0; rd_wrn = 1'b1; ben_n = 4'hF; oe_n = 1'b0; addr = '0; dq_in = '0;
    repeat (3) @(negedge clk);
    // R11: bus idle during reset
    checks++;
    if (dq_oe !== 1'b0) begin
      fails++;
      $display("FAIL R11: dq_oe in reset actual=%0b expected=0", dq_oe);
    end
    rst_n = 1'b1;
    cur_req = "R11";
    beat(1'b1, 4'hF); beat(1'b1, 4'hF); beat(1'b0, 4'hF); desel();

    cur_req = "R2";
    for (int i = 0; i < 16; i++) wr(i, 4'h0);
    cur_req = "R1";
    for (int i = 0; i < 16; i++) rd(i);
    cur_req = "R2";
    for (int i = 0; i < 8; i++) begin
      wr(16 + i, 4'h0);
      rd(i);
    end
    for (int i = 0; i < 8; i++) rd(16 + i);

    cur_req = "R3";
    wr(3, 4'b1110); wr(4, 4'b1101); wr(12, 4'b1011); wr(13, 4'b0111); wr(14, 4'hF);
    desel(); rd(3); rd(4); rd(12); rd(13); rd(14);

    cur_req = "R10";
    wr(5, 4'b0101); rd(5);
    wr(6, 4'h0); rd(6); rd(6);
    wr(15, 4'b1100); rd(15); wr(15, 4'b0011); rd(15);

    cur_req = "R4";
    rd(7); held(); held(); held(); desel(); desel();
    wr(8, 4'h0); held(); held(); desel(); held(); desel(); rd(8);
    rd(9); desel(); held(); held(); rd(10); desel(); desel();

    cur_req = "R5";
    drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF, 2);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'hF, 2);
    drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'hF, 2);
    drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 0);
    desel(); desel(); rd(0); desel(); desel();

    cur_req = "R6";
    rd(1); desel(); desel(); desel(); rd(2); rd(3); desel(); desel();

    cur_req = "R8";
    rd(6); beat(1'b0, 4'h0); beat(1'b0, 4'h0); beat(1'b1, 4'h0); beat(1'b1, 4'hF);
    cur_req = "R7";
    wr(9, 4'h0); beat(1'b1, 4'h0); beat(1'b1, 4'b1010); beat(1'b0, 4'h0);
    rd(8); rd(9); rd(10); rd(11);
    desel(); beat(1'b1, 4'hF); beat(1'b0, 4'h0); desel(); rd(9); desel(); desel();

    cur_req = "R9";
    oe_cur = 1'b1; rd(2); rd(3); desel(); desel();
    oe_cur = 1'b0; rd(2); desel(); desel();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule